// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

One channel of a timer. It sits beside a shared 16-bit counter and does not contain that counter. The channel watches the counter value and the counter's tick and period-end pulses. In capture mode it stores the counter value when the selected edge arrives on its pin input. In compare mode it signals each time the counter reaches its stored value. In edge-aligned PWM mode it drives a duty-cycle waveform whose falling point is set by the stored value.

A single event flag records the mode-specific event. It is cleared by an interlocked two-step sequence: a read while the flag is set arms the clear, and a later write of 0 completes it. Any event that lands between those two steps, or in the same cycle as the write, disarms the clear. When the interrupt enable is on, the interrupt request is a static level that follows the flag.

Top module: `cap_cmp_chan`

## Requirements
- R1: After reset, val_o, flag_o, pin_o and irq_o are all 0.
- R2: In capture mode (mode_i=00), edge_sel_i selects the capture edge: 01 is rising, 10 is falling and 11 is both. The pin passes through a two-flop synchronizer. A pin change made before clock edge k is captured at edge k+2: cnt_i at that edge is stored in val_o and flag_o sets.
- R3: In capture mode with edge_sel_i=00, pin changes neither alter val_o nor set flag_o.
- R4: In compare mode (mode_i=01), flag_o sets at a clock edge where tick_i=1 and cnt_i equals val_o. Without tick_i no match is taken.
- R5: In compare mode, pin_o toggles on every match taken under R4.
- R6: In PWM mode (mode_i=10), pin_o goes high at a tick with period_end_i=1 and goes low at a tick where cnt_i equals val_o. Period end wins when both occur together. With val_o=0, pin_o stays low.
- R7: In PWM mode, flag_o sets on each match taken under R6.
- R8: flag_o clears only when a write of 0 (flag_wr_i=1, flag_wdata_i=0) follows a read (flag_rd_i=1) made while flag_o was 1. A write of 0 without that read, or a write of 1, leaves flag_o set.
- R9: An event in the cycle of the write of 0, or between the read and the write, leaves flag_o set and cancels the armed clear.
- R10: irq_o is 1 exactly when flag_o and irq_en_i are both 1, in the same cycle, with no register in between.
- R11: val_wr_i loads val_wdata_i into val_o at the next edge. A capture in the same cycle takes priority over the write.
- R12: In mode 11 the channel is idle: flag_o does not set and pin_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Shared counter value |
| tick_i | input | 1 | Counter advance strobe |
| period_end_i | input | 1 | Last count of the period |
| pin_i | input | 1 | Channel pin input (asynchronous) |
| mode_i | input | 2 | 00 capture, 01 compare, 10 PWM, 11 idle |
| edge_sel_i | input | 2 | Capture edge: 00 none, 01 rise, 10 fall, 11 both |
| irq_en_i | input | 1 | Interrupt enable |
| flag_rd_i | input | 1 | Flag read strobe |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data |
| val_wr_i | input | 1 | Channel value write strobe |
| val_wdata_i | input | 16 | Channel value write data |
| val_o | output | 16 | Channel value register |
| pin_o | output | 1 | Compare/PWM output |
| flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Interrupt request level |

## Verification
A capture is due two edges after the pin change is seen by the first synchronizer flop, so the bench checks that the flag is still clear after two steps and set after the third. Compare and PWM results, flag clears and value writes take effect at the edge that samples the strobe. The bench drives each cycle's inputs 1 ns after an edge and reads the outputs at that same point after the next edge. irq_o is combinational, so it is read in the same cycle as the flag it follows. In compare mode a per-cycle bench model predicts the flag, the pin and the value under random ticks, matches, reads and writes.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [1:0] {
    MODE_CAP = 2'b00,
    MODE_CMP = 2'b01,
    MODE_PWM = 2'b10,
    MODE_OFF = 2'b11
  } ccp_mode_e;
endpackage

// File: rtl/ccp_sync_edge.sv
module ccp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ccp_flag_ctl.sv
module ccp_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  // event beats write; any event or write drops the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (wr_i) begin
      if (!wdata_i && armed_q) flag_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ccp_out_gen.sv
module ccp_out_gen
  import ccp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ccp_mode_e mode_i,
  input  logic      tick_i,
  input  logic      period_end_i,
  input  logic      match_i,
  input  logic      val_zero_i,
  output logic      pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else begin
      unique case (mode_i)
        MODE_CMP: if (match_i) pin_q <= ~pin_q;
        MODE_PWM: begin
          if (tick_i && period_end_i) pin_q <= ~val_zero_i;
          else if (match_i)           pin_q <= 1'b0;
        end
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = ((mode_i == MODE_CMP) || (mode_i == MODE_PWM)) ? pin_q : 1'b0;
endmodule

// File: rtl/cap_cmp_chan.sv
module cap_cmp_chan
  import ccp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             period_end_i,
  input  logic             pin_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             irq_en_i,
  input  logic             flag_rd_i,
  input  logic             flag_wr_i,
  input  logic             flag_wdata_i,
  input  logic             val_wr_i,
  input  logic [CNT_W-1:0] val_wdata_i,
  output logic [CNT_W-1:0] val_o,
  output logic             pin_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  ccp_mode_e        mode;
  logic             rise, fall, cap_ev, match_ev, chan_ev;
  logic [CNT_W-1:0] val_q;

  assign mode = ccp_mode_e'(mode_i);

  ccp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign cap_ev   = (mode == MODE_CAP) &&
                    ((edge_sel_i[0] && rise) || (edge_sel_i[1] && fall));
  assign match_ev = ((mode == MODE_CMP) || (mode == MODE_PWM)) &&
                    tick_i && (cnt_i == val_q);
  assign chan_ev  = cap_ev || match_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= ZERO;
    else if (cap_ev)   val_q <= cnt_i;
    else if (val_wr_i) val_q <= val_wdata_i;
  end

  ccp_flag_ctl u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chan_ev),
    .rd_i   (flag_rd_i),
    .wr_i   (flag_wr_i),
    .wdata_i(flag_wdata_i),
    .flag_o (flag_o)
  );

  ccp_out_gen u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .tick_i      (tick_i),
    .period_end_i(period_end_i),
    .match_i     (match_ev),
    .val_zero_i  (val_q == ZERO),
    .pin_o       (pin_o)
  );

  assign val_o = val_q;
  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/ccp_chan_checker.sv
module ccp_chan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic             period_end_i,
  input logic [1:0]       mode_i,
  input logic [1:0]       edge_sel_i,
  input logic             irq_en_i,
  input logic             flag_wr_i,
  input logic             flag_wdata_i,
  input logic             val_wr_i,
  input logic [CNT_W-1:0] val_o,
  input logic             pin_o,
  input logic             flag_o,
  input logic             irq_o
);
  assert_noedge_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && edge_sel_i == 2'b00 && !val_wr_i) |=> $stable(val_o));

  assert_cmp_sets_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && tick_i && cnt_i == val_o) |=> flag_o);

  assert_pwm_zero_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && val_o == '0 && !val_wr_i && tick_i && period_end_i)
      |=> (mode_i != 2'b10 || !pin_o));

  assert_clear_needs_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_wr_i && !flag_wdata_i));

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i || !flag_o) |-> !irq_o);

  assert_irq_on_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  assert_idle_no_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !flag_o) |=> !flag_o);

  assert_idle_pin_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> !pin_o);
endmodule

bind cap_cmp_chan ccp_chan_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_i       (cnt_i),
  .tick_i      (tick_i),
  .period_end_i(period_end_i),
  .mode_i      (mode_i),
  .edge_sel_i  (edge_sel_i),
  .irq_en_i    (irq_en_i),
  .flag_wr_i   (flag_wr_i),
  .flag_wdata_i(flag_wdata_i),
  .val_wr_i    (val_wr_i),
  .val_o       (val_o),
  .pin_o       (pin_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o)
);

// File: tb/tb_cap_cmp_chan.sv
`timescale 1ns/100ps
module tb_cap_cmp_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        tick_i = 1'b0, period_end_i = 1'b0, pin_i = 1'b0;
  logic [1:0]  mode_i = 2'b01, edge_sel_i = 2'b00;
  logic        irq_en_i = 1'b0, flag_rd_i = 1'b0, flag_wr_i = 1'b0, flag_wdata_i = 1'b0;
  logic        val_wr_i = 1'b0;
  logic [15:0] val_wdata_i = '0;
  logic [15:0] val_o;
  logic        pin_o, flag_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cap_cmp_chan dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic idle_strobes();
    tick_i = 0; period_end_i = 0; flag_rd_i = 0; flag_wr_i = 0; val_wr_i = 0;
  endtask

  task automatic clear_flag();
    idle_strobes();
    flag_rd_i = 1; step();
    flag_rd_i = 0; flag_wr_i = 1; flag_wdata_i = 0; step();
    flag_wr_i = 0;
  endtask

  // compare-mode reference model
  logic        m_flag, m_arm, m_pin;
  logic [15:0] m_val;

  function automatic logic cmp_event(input logic tk, input logic [15:0] c, input logic [15:0] v);
    return tk && (c == v);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R1 val", val_o, 0); chk("R1 flag", flag_o, 0);
    chk("R1 pin", pin_o, 0); chk("R1 irq", irq_o, 0);
    step(); rst_ni = 1; step();
    chk("R1 val after release", val_o, 0);

    // random compare phase: R4 R5 R8 R9 R10 R11
    m_flag = 0; m_arm = 0; m_pin = 0; m_val = 0;
    mode_i = 2'b01;
    for (int it = 0; it < 3000; it++) begin
      logic ev;
      cnt_i        = 16'($urandom % 6);
      tick_i       = ($urandom % 3) != 0;
      flag_rd_i    = ($urandom % 4) == 0;
      flag_wr_i    = ($urandom % 5) == 0;
      flag_wdata_i = ($urandom % 4) == 0;
      val_wr_i     = ($urandom % 10) == 0;
      val_wdata_i  = 16'($urandom % 6);
      irq_en_i     = $urandom % 2;
      ev = cmp_event(tick_i, cnt_i, m_val);
      if (ev) begin m_flag = 1; m_arm = 0; m_pin = ~m_pin; end
      else if (flag_wr_i) begin
        if (!flag_wdata_i && m_arm) m_flag = 0;
        m_arm = 0;
      end else if (flag_rd_i && m_flag) m_arm = 1;
      if (val_wr_i) m_val = val_wdata_i;
      step();
      chk("R4/R8/R9 flag", flag_o, m_flag);
      chk("R5 pin toggle", pin_o, m_pin);
      chk("R11 val", val_o, m_val);
      chk("R10 irq", irq_o, m_flag & irq_en_i);
    end
    idle_strobes(); irq_en_i = 0;

    // directed R8: write 0 without read, write 1
    val_wr_i = 1; val_wdata_i = 16'h0004; step(); val_wr_i = 0;
    cnt_i = 16'h0004; tick_i = 1; step(); tick_i = 0;
    chk("R4 match sets flag", flag_o, 1);
    flag_wr_i = 1; flag_wdata_i = 0; step(); flag_wr_i = 0;
    chk("R8 write0 without read keeps flag", flag_o, 1);
    flag_rd_i = 1; step(); flag_rd_i = 0;
    flag_wr_i = 1; flag_wdata_i = 1; step(); flag_wr_i = 0;
    chk("R8 write1 keeps flag", flag_o, 1);
    // R9: event between read and write
    flag_rd_i = 1; step(); flag_rd_i = 0;
    tick_i = 1; step(); tick_i = 0;
    flag_wr_i = 1; flag_wdata_i = 0; step(); flag_wr_i = 0;
    chk("R9 event between steps keeps flag", flag_o, 1);
    // R9: event in same cycle as write
    flag_rd_i = 1; step(); flag_rd_i = 0;
    flag_wr_i = 1; flag_wdata_i = 0; tick_i = 1; step(); flag_wr_i = 0; tick_i = 0;
    chk("R9 event with write keeps flag", flag_o, 1);
    // R4: match without tick
    clear_flag();
    chk("R8 proper clear", flag_o, 0);
    tick_i = 0; step(3);
    chk("R4 no tick no flag", flag_o, 0);
    irq_en_i = 1; tick_i = 1; step(); tick_i = 0;
    chk("R10 irq follows flag", irq_o, 1);
    irq_en_i = 0; #1;
    chk("R10 irq masked", irq_o, 0);

    // capture mode R2
    clear_flag();
    mode_i = 2'b00; edge_sel_i = 2'b01; pin_i = 0; step(4);
    cnt_i = 16'h1234; pin_i = 1; step(2);
    chk("R2 capture not yet due", flag_o, 0);
    step();
    chk("R2 rising capture flag", flag_o, 1);
    chk("R2 rising capture value", val_o, 16'h1234);
    clear_flag();
    cnt_i = 16'h2222; pin_i = 0; step(4);
    chk("R2 falling ignored on rise select", flag_o, 0);
    chk("R2 value kept", val_o, 16'h1234);
    edge_sel_i = 2'b10; pin_i = 1; step(4);
    chk("R2 rising ignored on fall select", flag_o, 0);
    cnt_i = 16'h5555; pin_i = 0; step(3);
    chk("R2 falling capture value", val_o, 16'h5555);
    chk("R2 falling capture flag", flag_o, 1);
    clear_flag();
    edge_sel_i = 2'b11; cnt_i = 16'h0abc; pin_i = 1; step(3);
    chk("R2 both-edge rise", val_o, 16'h0abc);
    cnt_i = 16'h0def; pin_i = 0; step(3);
    chk("R2 both-edge fall", val_o, 16'h0def);
    clear_flag();
    // R3
    edge_sel_i = 2'b00;
    for (int k = 0; k < 4; k++) begin
      cnt_i = 16'(16'h7000 + k); pin_i = ~pin_i; step(4);
    end
    chk("R3 no capture value", val_o, 16'h0def);
    chk("R3 no capture flag", flag_o, 0);
    // R11 capture beats write
    edge_sel_i = 2'b01; pin_i = 0; step(4);
    cnt_i = 16'h4321; pin_i = 1; step(2);
    val_wr_i = 1; val_wdata_i = 16'haaaa; step(); val_wr_i = 0;
    chk("R11 capture wins over write", val_o, 16'h4321);
    val_wr_i = 1; val_wdata_i = 16'h0003; step(); val_wr_i = 0;
    chk("R11 plain write", val_o, 16'h0003);
    clear_flag();
    chk("R1 pin low in capture", pin_o, 0);

    // PWM R6 R7, val=3, period 0..7
    mode_i = 2'b10;
    for (int c = 0; c < 8; c++) begin
      cnt_i = 16'(c); tick_i = 1; period_end_i = (c == 7); step();
    end
    clear_flag();
    begin
      logic ep = 1;
      for (int c = 0; c < 8; c++) begin
        cnt_i = 16'(c); tick_i = 1; period_end_i = (c == 7); step();
        if (c == 7) ep = 1; else if (c == 3) ep = 0;
        chk("R6 pwm waveform", pin_o, ep);
        if (c == 2) chk("R7 no flag before match", flag_o, 0);
        if (c == 3) chk("R7 flag at match", flag_o, 1);
      end
    end
    // stalled counter at match must not rearm flag
    clear_flag();
    cnt_i = 16'h0003; tick_i = 0; step(4);
    chk("R7 no flag without tick", flag_o, 0);
    // val=0 constant low
    val_wr_i = 1; val_wdata_i = 16'h0000; step(); val_wr_i = 0;
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 8; c++) begin
        cnt_i = 16'(c); tick_i = 1; period_end_i = (c == 7); step();
        chk("R6 zero duty low", pin_o, 0);
      end
    end
    idle_strobes();

    // idle mode R12
    clear_flag();
    mode_i = 2'b11; cnt_i = 16'h0000; tick_i = 1;
    edge_sel_i = 2'b11; pin_i = ~pin_i; step(4);
    period_end_i = 1; step(); idle_strobes();
    chk("R12 idle no flag", flag_o, 0);
    chk("R12 idle pin low", pin_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule